// File: doc/BRIEF.md
# Chainable TDM Serial Audio Output Stage

This block is the serial output port of one stereo stage that can be chained with identical stages onto a single time-division-multiplexed data line. Each frame, the stage shifts out its own left and right samples in the first two 32-bit slots. After that it shifts through whatever arrives on its chain input, delayed by exactly two slots. A chain of N stages therefore fills a frame with 2N channels. The first stage has its chain input tied low, so trailing slots that nobody fills read as zero.

All logic runs on one fast clock `clk`. In slave mode the bit clock and frame clock come in from outside. They are synchronised and edge-detected into single-cycle strobes. In master mode the stage divides `clk` to make the bit clock and produces a one-bit-wide frame pulse every 256 bit clocks. Parallel samples are captured on a valid strobe and held. They are committed to the serial frame only at a frame start, so a frame always carries one consistent pair.

Top module: `tdm_chain_out`

## Requirements
- R1: Each own slot is 32 bit clocks wide, with the sample left-justified (sample MSB first) and every bit past the selected word length driven 0.
- R2: `wordSel` picks the word length: 0 = 16, 1 = 20, 2 = 24, 3 = 32 bits. The input samples are MSB-aligned: bit 31 is the sample MSB, and bits below the word length are discarded.
- R3: `sdout` changes only after a falling bit-clock edge, so it is stable when the receiver samples on the rising edge.
- R4: A frame starts at a rising bit-clock edge where the frame clock is sampled high after having been sampled low at the previous rising edge. The MSB of slot 0 is driven on the next falling edge.
- R5: The own left sample occupies slot 0 (bit positions 0..31 of the frame) and the own right sample occupies slot 1 (positions 32..63).
- R6: From position 64 onward, `sdout` carries the chain input delayed by exactly 64 bit clocks: the chain bit sampled at position p appears at position p+64.
- R7: Samples taken on `sampleValid` are committed at the next frame start. A pair that arrives mid-frame does not alter the frame in progress. Without a new pair, the previous pair repeats.
- R8: In master mode the bit clock period is 2*BCLK_HALF cycles of `clk` and a frame is 256 bit clocks. `frmOut` is high for exactly one bit clock, across the rising edge before slot 0's MSB, and falls when that MSB is driven.
- R9: In slave mode the stage resynchronises to a frame clock that arrives early or late, with no frame lost after the one that was mistimed.
- R10: In slave mode `bclkOut` and `frmOut` are held low.
- R11: After reset `sdout`, `bclkOut` and `frmOut` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic runs on it |
| rstN | input | 1 | Active-low synchronous reset |
| isMaster | input | 1 | 1 = generate bit and frame clocks, 0 = follow external ones |
| wordSel | input | 2 | Word length select (16/20/24/32) |
| leftIn | input | 32 | Left sample, MSB-aligned |
| rightIn | input | 32 | Right sample, MSB-aligned |
| sampleValid | input | 1 | One-cycle strobe capturing leftIn/rightIn |
| bclkIn | input | 1 | External bit clock (slave mode) |
| frmIn | input | 1 | External frame clock (slave mode) |
| chainIn | input | 1 | Serial data from the previous stage |
| bclkOut | output | 1 | Generated bit clock (master mode) |
| frmOut | output | 1 | Generated frame pulse (master mode) |
| sdout | output | 1 | Serial TDM data |

## Verification
The hardest case to reach is a frame boundary that is not where the stage expects it. Examples are a frame clock arriving after 100 or after 160 bit clocks, or a new sample pair landing in the middle of a frame. The bench drives the external bit and frame clocks bit by bit, so each frame has its own length and a sample strobe can be placed at any chosen bit. Every captured bit is then compared with a model of the slot layout and the 64-bit chain delay. Master mode is checked by following the generated clocks edge by edge and feeding the chain input from the bench after each falling edge.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;
  localparam int SLOT_BITS    = 32;
  localparam int OWN_BITS     = 2 * SLOT_BITS;
  localparam int MASTER_FRAME = 256;
  localparam int POS_W        = 10;

  typedef struct packed {
    logic             rise;   // bit-clock rising edge seen this cycle
    logic             fall;   // bit-clock falling edge seen this cycle
    logic             load;   // frame start: commit held samples
    logic [POS_W-1:0] pos;    // bit position driven at this fall
  } tdmStrobe_t;
endpackage

// File: rtl/tdm_chain_ctrl.sv
module tdm_chain_ctrl
  import tdm_chain_pkg::*;
#(
  parameter int BCLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       isMaster,
  input  logic       bclkIn,
  input  logic       frmIn,
  output tdmStrobe_t strb,
  output logic       bclkOut,
  output logic       frmOut
);
  localparam int HW = (BCLK_HALF > 1) ? $clog2(BCLK_HALF) : 1;
  localparam logic [POS_W-1:0] POS_MAX  = '1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(MASTER_FRAME - 1);

  logic [2:0]       bSync;
  logic [1:0]       fSync;
  logic [HW-1:0]    halfCnt;
  logic             bclkReg, frmReg, frmPrev, startPend;
  logic [POS_W-1:0] posReg, nextPos;
  logic             mTick, riseEv, fallEv, frameNow, frameEdge;

  assign mTick     = isMaster && (halfCnt == HW'(BCLK_HALF - 1));
  assign riseEv    = isMaster ? (mTick && !bclkReg) : (bSync[1] && !bSync[2]);
  assign fallEv    = isMaster ? (mTick && bclkReg)  : (!bSync[1] && bSync[2]);
  assign frameNow  = isMaster ? frmReg : fSync[1];
  assign frameEdge = frameNow && !frmPrev;

  always_comb begin
    if (startPend)                          nextPos = '0;
    else if (isMaster && posReg >= POS_LAST) nextPos = '0;
    else if (posReg == POS_MAX)             nextPos = posReg;
    else                                    nextPos = posReg + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSync <= '0;
      fSync <= '0;
    end else begin
      bSync <= {bSync[1:0], bclkIn};
      fSync <= {fSync[0], frmIn};
    end
  end

  // master-mode clock divider and frame pulse
  always_ff @(posedge clk) begin
    if (!rstN || !isMaster) begin
      halfCnt <= '0;
      bclkReg <= 1'b0;
      frmReg  <= 1'b0;
    end else begin
      if (mTick) begin
        halfCnt <= '0;
        bclkReg <= !bclkReg;
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
      if (fallEv) frmReg <= (nextPos == POS_LAST);
    end
  end

  // frame detection and bit position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frmPrev   <= 1'b0;
      startPend <= 1'b0;
      posReg    <= POS_MAX;
    end else begin
      if (riseEv) begin
        frmPrev <= frameNow;
        if (frameEdge) startPend <= 1'b1;
      end
      if (fallEv) begin
        posReg    <= nextPos;
        startPend <= 1'b0;
      end
    end
  end

  assign strb.rise = riseEv;
  assign strb.fall = fallEv;
  assign strb.load = riseEv && frameEdge;
  assign strb.pos  = nextPos;
  assign bclkOut   = bclkReg;
  assign frmOut    = frmReg;
endmodule

// File: rtl/tdm_chain_dp.sv
module tdm_chain_dp
  import tdm_chain_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  tdmStrobe_t           strb,
  input  logic [1:0]           wordSel,
  input  logic [SLOT_BITS-1:0] leftIn,
  input  logic [SLOT_BITS-1:0] rightIn,
  input  logic                 sampleValid,
  input  logic                 chainIn,
  output logic                 sdout
);
  localparam int IDX_W = $clog2(SLOT_BITS);

  logic [SLOT_BITS-1:0] holdL, holdR, curL, curR, slotWord, lenMask;
  logic [OWN_BITS-1:0]  chainSr;
  logic [IDX_W-1:0]     bitIdx;
  logic [6:0]           wordLen;
  logic                 ownRegion, nextBit;

  always_comb begin
    case (wordSel)
      2'd0:    wordLen = 7'd16;
      2'd1:    wordLen = 7'd20;
      2'd2:    wordLen = 7'd24;
      default: wordLen = 7'd32;
    endcase
  end

  assign lenMask   = ~({SLOT_BITS{1'b1}} >> wordLen);
  assign ownRegion = strb.pos < POS_W'(OWN_BITS);
  assign bitIdx    = strb.pos[IDX_W-1:0];
  assign slotWord  = (strb.pos[IDX_W] ? curR : curL) & lenMask;
  assign nextBit   = ownRegion ? slotWord[(SLOT_BITS-1) - 32'(bitIdx)]
                               : chainSr[OWN_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdL   <= '0;
      holdR   <= '0;
      curL    <= '0;
      curR    <= '0;
      chainSr <= '0;
      sdout   <= 1'b0;
    end else begin
      if (sampleValid) begin
        holdL <= leftIn;
        holdR <= rightIn;
      end
      if (strb.load) begin
        curL <= holdL;
        curR <= holdR;
      end
      if (strb.rise) chainSr <= {chainSr[OWN_BITS-2:0], chainIn};
      if (strb.fall) sdout <= nextBit;
    end
  end
endmodule

// File: rtl/tdm_chain_out.sv
module tdm_chain_out
  import tdm_chain_pkg::*;
#(
  parameter int BCLK_HALF = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        isMaster,
  input  logic [1:0]  wordSel,
  input  logic [31:0] leftIn,
  input  logic [31:0] rightIn,
  input  logic        sampleValid,
  input  logic        bclkIn,
  input  logic        frmIn,
  input  logic        chainIn,
  output logic        bclkOut,
  output logic        frmOut,
  output logic        sdout
);
  tdmStrobe_t strb;

  tdm_chain_ctrl #(.BCLK_HALF(BCLK_HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .bclkIn(bclkIn),
    .frmIn(frmIn), .strb(strb), .bclkOut(bclkOut), .frmOut(frmOut)
  );

  tdm_chain_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wordSel(wordSel),
    .leftIn(leftIn), .rightIn(rightIn), .sampleValid(sampleValid),
    .chainIn(chainIn), .sdout(sdout)
  );
endmodule

// File: rtl/tdm_chain_out_chk.sv
module tdm_chain_out_chk
  import tdm_chain_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       isMaster,
  input logic [1:0] wordSel,
  input tdmStrobe_t strb,
  input logic       sdout,
  input logic       bclkOut,
  input logic       frmOut
);
  logic [5:0] chkLen;
  always_comb begin
    case (wordSel)
      2'd0:    chkLen = 6'd16;
      2'd1:    chkLen = 6'd20;
      2'd2:    chkLen = 6'd24;
      default: chkLen = 6'd32;
    endcase
  end

  AST_SDOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fall |=> $stable(sdout)); // R3

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fall && strb.pos < POS_W'(OWN_BITS) && {1'b0, strb.pos[4:0]} >= chkLen)
    |=> !sdout); // R1

  AST_MASTER_FRAME_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && strb.fall && strb.pos == '0) |=> !frmOut); // R8

  AST_SLAVE_CLOCKS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !isMaster |=> (!bclkOut && !frmOut)); // R10
endmodule

bind tdm_chain_out tdm_chain_out_chk u_chk (
  .clk(clk), .rstN(rstN), .isMaster(isMaster), .wordSel(wordSel),
  .strb(strb), .sdout(sdout), .bclkOut(bclkOut), .frmOut(frmOut)
);

// File: tb/tdm_chain_out_tb.sv
module tdm_chain_out_tb;
  localparam int HALF = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, isMaster, sampleValid, bclkIn, frmIn, chainIn;
  logic [1:0]  wordSel;
  logic [31:0] leftIn, rightIn;
  logic        bclkOut, frmOut, sdout;

  tdm_chain_out #(.BCLK_HALF(HALF)) u_dut (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .wordSel(wordSel),
    .leftIn(leftIn), .rightIn(rightIn), .sampleValid(sampleValid),
    .bclkIn(bclkIn), .frmIn(frmIn), .chainIn(chainIn),
    .bclkOut(bclkOut), .frmOut(frmOut), .sdout(sdout)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  logic chn [0:255];
  logic cap [0:255];
  logic [31:0] expL = '0, expR = '0;

  task automatic report(input bit ok, input string msg);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic modelBit(input int p, input logic [31:0] l, input logic [31:0] r,
                                    input logic [1:0] ws);
    int len;
    int idx;
    logic [31:0] w;
    len = (ws == 2'd0) ? 16 : (ws == 2'd1) ? 20 : (ws == 2'd2) ? 24 : 32;
    if (p >= 64) return chn[p-64];
    idx = p % 32;
    if (idx >= len) return 1'b0;
    w = (p < 32) ? l : r;
    return w[31-idx];
  endfunction

  task automatic compareFrame(input int nbits, input logic [31:0] l, input logic [31:0] r,
                              input string req);
    int bad = -1;
    logic e;
    for (int i = 0; i < nbits; i++) begin
      e = modelBit(i, l, r, wordSel);
      if (bad < 0 && cap[i] !== e) bad = i;
    end
    if (bad >= 0)
      report(1'b0, $sformatf("%s frame bit %0d actual %b expected %b", req, bad,
                             cap[bad], modelBit(bad, l, r, wordSel)));
    else
      report(1'b1, req);
  endtask

  task automatic doReset(input logic master);
    @(negedge clk);
    rstN = 1'b0; isMaster = master; sampleValid = 1'b0;
    bclkIn = 1'b0; frmIn = 1'b0; chainIn = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
  endtask

  // one externally clocked frame; a sample pair may be strobed at bit pulseAt
  task automatic slaveFrame(input int nbits, input int pulseAt, input logic [31:0] pL,
                            input logic [31:0] pR, input bit doCheck, input string req);
    for (int i = 0; i < 256; i++) chn[i] = 1'($urandom);
    for (int i = 0; i < nbits; i++) begin
      bclkIn = 1'b0;
      frmIn = (i == nbits - 1);
      chainIn = chn[i];
      if (i == pulseAt) begin
        leftIn = pL; rightIn = pR; sampleValid = 1'b1;
        @(negedge clk);
        sampleValid = 1'b0;
        repeat (7) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
      cap[i] = sdout;
      bclkIn = 1'b1;
      repeat (8) @(negedge clk);
    end
    if (doCheck) compareFrame(nbits, expL, expR, req);
    if (pulseAt >= 0) begin
      expL = pL;
      expR = pR;
    end
  endtask

  task automatic t_reset;
    doReset(1'b0);
    wordSel = 2'd3;
    @(negedge clk);
    report(sdout == 1'b0, $sformatf("R11 sdout actual %b expected 0", sdout));
    report(bclkOut == 1'b0, $sformatf("R11 bclkOut actual %b expected 0", bclkOut));
    report(frmOut == 1'b0, $sformatf("R11 frmOut actual %b expected 0", frmOut));
  endtask

  task automatic t_slaveBasic;
    wordSel = 2'd3;
    slaveFrame(128, 20, 32'h9ABC_DEF1, 32'h5A5A_A5A7, 1'b0, "");
    slaveFrame(128, -1, '0, '0, 1'b1, "R3 R4 R5 R6 32-bit frame");
    slaveFrame(128, -1, '0, '0, 1'b1, "R5 R6 second frame");
  endtask

  task automatic t_wordLen;
    for (int ws = 0; ws < 3; ws++) begin
      wordSel = 2'(ws);
      slaveFrame(128, -1, '0, '0, 1'b1, $sformatf("R1 R2 wordSel %0d", ws));
    end
    wordSel = 2'd3;
  endtask

  task automatic t_hold;
    slaveFrame(128, -1, '0, '0, 1'b1, "R7 repeat without new pair");
    slaveFrame(128, 5, 32'hC3C3_0F0F, 32'h1234_5678, 1'b1, "R7 mid-frame pair ignored");
    slaveFrame(128, -1, '0, '0, 1'b1, "R7 new pair committed");
  endtask

  task automatic t_resync;
    slaveFrame(100, -1, '0, '0, 1'b1, "R9 short frame");
    slaveFrame(160, -1, '0, '0, 1'b1, "R9 R6 after early frame, long frame");
    slaveFrame(128, -1, '0, '0, 1'b1, "R9 after late frame");
    report(bclkOut == 1'b0 && frmOut == 1'b0,
           $sformatf("R10 slave clocks actual %b%b expected 00", bclkOut, frmOut));
  endtask

  task automatic t_master;
    int pos = 0;
    int cyc = 0;
    int lastRise = -1;
    int periodBad = 0;
    int frames = 0;
    int frmHighs = 0;
    bit started = 0;
    bit startNext = 0;
    logic prevB = 1'b0;
    doReset(1'b1);
    wordSel = 2'd2;
    for (int i = 0; i < 256; i++) chn[i] = 1'($urandom);
    leftIn = 32'hA5F0_3C99; rightIn = 32'h0FF0_E1D3; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      cyc++;
      if (bclkOut && !prevB) begin
        if (lastRise >= 0 && cyc - lastRise != 2 * HALF) periodBad++;
        lastRise = cyc;
        if (pos < 256) cap[pos] = sdout;
        if (frmOut) begin
          frmHighs++;
          if (started) begin
            frames++;
            compareFrame(256, 32'hA5F0_3C99, 32'h0FF0_E1D3, "R8 R5 R6 master frame");
            report(pos == 255, $sformatf("R8 frame length actual %0d expected 256", pos + 1));
            report(frmHighs == 1, $sformatf("R8 frame pulse bits actual %0d expected 1", frmHighs));
          end
          frmHighs = 0;
          started = 1;
          startNext = 1;
        end
      end
      if (!bclkOut && prevB) begin
        pos = startNext ? 0 : pos + 1;
        startNext = 0;
        chainIn = (pos < 256) ? chn[pos] : 1'b0;
      end
      prevB = bclkOut;
      if (frames == 2) break;
    end
    report(frames == 2, $sformatf("R8 master frames seen actual %0d expected 2", frames));
    report(periodBad == 0, $sformatf("R8 bit clock period errors actual %0d expected 0", periodBad));
  endtask

  initial begin
    rstN = 1'b0; isMaster = 1'b0; wordSel = 2'd3; leftIn = '0; rightIn = '0;
    sampleValid = 1'b0; bclkIn = 1'b0; frmIn = 1'b0; chainIn = 1'b0;
    t_reset();
    t_slaveBasic();
    t_wordLen();
    t_hold();
    t_resync();
    t_master();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule